// File: doc/BRIEF.md
# Fetch Redirect and Epoch Controller

This block is the steering logic at the front of a three-stage fetch/decode/execute pipeline in which both the decode stage and the execute stage may send the fetch address somewhere new. It owns the fetch program counter and two global epoch counters: one that advances on execute redirects and one that advances on decode redirects. Each fetched instruction carries a copy of both counters. Later stages hand these tags back to the block to learn whether the instruction is still on the correct path.

A redirect is honoured only when the instruction that raised it still belongs to the current epochs. A late redirect from a flushed instruction therefore cannot move the PC. The counters are 8 bits wide and wrap. As long as fewer than 128 redirects are in flight, an old tag never matches the current value again. When the execute and decode stages redirect in the same cycle, the execute request wins. With no redirect, the PC advances on the fetch handshake to the predicted address, or to PC + 4 when no prediction is offered.

Top module: `epoch_redirect_ctl`

## Requirements
- R1: After a synchronous active-low reset, the fetch PC equals the parameter RESET_PC and both the execute epoch and the decode epoch read zero.
- R2: An execute redirect whose execute-epoch tag equals the current execute epoch is accepted. One clock later the fetch PC equals its target and the execute epoch is one higher. The decode epoch is unchanged, and the fetch handshake has no effect.
- R3: A decode redirect whose execute-epoch tag and decode-epoch tag both equal the current epochs is accepted when no execute redirect is accepted in the same cycle. One clock later the fetch PC equals its target and the decode epoch is one higher. The execute epoch is unchanged.
- R4: When an execute redirect and a decode redirect are both acceptable in the same cycle, only the execute redirect is applied. The PC takes the execute target, the execute epoch rises by one and the decode epoch holds.
- R5: A decode redirect with a stale execute-epoch tag or a stale decode-epoch tag is ignored. Neither the PC nor any epoch is affected by it.
- R6: An execute redirect whose execute-epoch tag differs from the current execute epoch is ignored.
- R7: With no accepted redirect and the fetch handshake high, the next PC is the predicted PC when the prediction-valid input is high, and otherwise the current PC + 4.
- R8: With no accepted redirect and the fetch handshake low, the PC holds.
- R9: The execute kill flag is high in the same cycle exactly when the presented execute-epoch tag differs from the current execute epoch. The decode kill flag is high exactly when either presented tag differs from its current epoch.
- R10: Epoch counters are 8 bits wide and wrap from 255 to 0 on an accepted redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_adv_i | input | 1 | Fetch consumed the current PC this cycle |
| pred_valid_i | input | 1 | Predicted next PC is valid |
| pred_pc_i | input | XLEN | Predicted next PC |
| dec_redir_valid_i | input | 1 | Decode requests a redirect |
| dec_redir_pc_i | input | XLEN | Decode redirect target |
| dec_redir_eep_i | input | EPW | Execute-epoch tag of the redirecting instruction |
| dec_redir_dep_i | input | EPW | Decode-epoch tag of the redirecting instruction |
| exe_redir_valid_i | input | 1 | Execute requests a redirect |
| exe_redir_pc_i | input | XLEN | Execute redirect target |
| exe_redir_eep_i | input | EPW | Execute-epoch tag of the redirecting instruction |
| dec_chk_eep_i | input | EPW | Execute-epoch tag of the instruction now in decode |
| dec_chk_dep_i | input | EPW | Decode-epoch tag of the instruction now in decode |
| exe_chk_eep_i | input | EPW | Execute-epoch tag of the instruction now in execute |
| fetch_pc_o | output | XLEN | PC to fetch |
| fetch_eep_o | output | EPW | Current execute epoch, used to tag the fetch |
| fetch_dep_o | output | EPW | Current decode epoch, used to tag the fetch |
| dec_kill_o | output | 1 | Instruction in decode is off-path |
| exe_kill_o | output | 1 | Instruction in execute is off-path |

## Verification
A sequential table drives sequential fetches, both with and without a prediction, as well as stalls, lone execute redirects, lone decode redirects and simultaneous redirects. This separates the next-PC mux from the priority logic. Stale redirects are sent with a bad execute tag alone, a bad decode tag alone, and next to a good redirect from the other stage. This shows that each tag comparison is wired independently and that a rejected request does not hide an accepted one. Separate tests drive the kill flags with every tag-mismatch combination and push the execute epoch through its wrap. A reset is applied in the middle of the run.

// File: rtl/rdr_pkg.sv
// Shared types for the fetch redirect controller.
// Assumes nothing beyond IEEE 1800-2017.
package rdr_pkg;

    // Which source steers the fetch PC in the current cycle.
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_SEQ  = 2'd1,
        SRC_DEC  = 2'd2,
        SRC_EXE  = 2'd3
    } pc_src_e;

endpackage

// File: rtl/rdr_epoch_ctr.sv
// Wrapping epoch counter. It increments once for each cycle in which bump_i is high.
// Assumes the caller bumps only on an accepted redirect.
module rdr_epoch_ctr #(
    parameter int EPW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bump_i,
    output logic [EPW-1:0] value_o
);

    localparam logic [EPW-1:0] EP_ONE = EPW'(1);

    logic [EPW-1:0] cnt_q;

    // Hold or advance the epoch; zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (bump_i) cnt_q <= cnt_q + EP_ONE;
    end

    assign value_o = cnt_q;

endmodule

// File: rtl/rdr_redirect_arb.sv
// Redirect acceptance and priority. It checks each request's epoch tags against
// the live epochs and gives execute priority over decode.
// Assumes tags travel unchanged with their instruction.
module rdr_redirect_arb
    import rdr_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int EPW  = 8
) (
    input  logic            fetch_adv_i,
    input  logic            dec_valid_i,
    input  logic [XLEN-1:0] dec_pc_i,
    input  logic [EPW-1:0]  dec_eep_i,
    input  logic [EPW-1:0]  dec_dep_i,
    input  logic            exe_valid_i,
    input  logic [XLEN-1:0] exe_pc_i,
    input  logic [EPW-1:0]  exe_eep_i,
    input  logic [EPW-1:0]  cur_eep_i,
    input  logic [EPW-1:0]  cur_dep_i,
    output logic            exe_take_o,
    output logic            dec_take_o,
    output pc_src_e         src_o,
    output logic [XLEN-1:0] tgt_pc_o
);

    logic exe_ok;
    logic dec_ok;

    // A request qualifies only while its tags are current.
    always_comb begin
        exe_ok = exe_valid_i && (exe_eep_i == cur_eep_i);
        dec_ok = dec_valid_i && (dec_eep_i == cur_eep_i) && (dec_dep_i == cur_dep_i);
    end

    // Execute never yields; decode wins only when execute is silent.
    always_comb begin
        exe_take_o = exe_ok;
        dec_take_o = dec_ok && !exe_ok;
        tgt_pc_o   = exe_ok ? exe_pc_i : dec_pc_i;
        if (exe_ok)           src_o = SRC_EXE;
        else if (dec_ok)      src_o = SRC_DEC;
        else if (fetch_adv_i) src_o = SRC_SEQ;
        else                  src_o = SRC_HOLD;
    end

endmodule

// File: rtl/rdr_fetch_pc.sv
// Fetch PC register with its next-PC mux.
// Assumes src_i comes from the redirect arbiter for the same cycle.
module rdr_fetch_pc
    import rdr_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter logic [XLEN-1:0] RESET_PC = '0,
    parameter int              PC_STEP  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pc_src_e         src_i,
    input  logic [XLEN-1:0] tgt_pc_i,
    input  logic            pred_valid_i,
    input  logic [XLEN-1:0] pred_pc_i,
    output logic [XLEN-1:0] pc_o
);

    localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_d;
    logic [XLEN-1:0] seq_pc;

    // Sequential successor: the prediction when offered, else PC + step.
    assign seq_pc = pred_valid_i ? pred_pc_i : (pc_q + STEP);

    // Choose the next PC from the arbiter decision.
    always_comb begin
        unique case (src_i)
            SRC_EXE, SRC_DEC: pc_d = tgt_pc_i;
            SRC_SEQ:          pc_d = seq_pc;
            default:          pc_d = pc_q;
        endcase
    end

    // Register the PC; load the reset vector on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= pc_d;
    end

    assign pc_o = pc_q;

endmodule

// File: rtl/rdr_kill_check.sv
// Per-stage wrong-path detector. It compares the presented tags with the live epochs.
// Assumes the tags are valid whenever the stage holds an instruction.
module rdr_kill_check #(
    parameter int EPW = 8
) (
    input  logic [EPW-1:0] cur_eep_i,
    input  logic [EPW-1:0] cur_dep_i,
    input  logic [EPW-1:0] dec_eep_i,
    input  logic [EPW-1:0] dec_dep_i,
    input  logic [EPW-1:0] exe_eep_i,
    output logic           dec_kill_o,
    output logic           exe_kill_o
);

    // Execute checks one tag; decode checks both.
    always_comb begin
        exe_kill_o = (exe_eep_i != cur_eep_i);
        dec_kill_o = (dec_eep_i != cur_eep_i) || (dec_dep_i != cur_dep_i);
    end

endmodule

// File: rtl/epoch_redirect_ctl.sv
// Front-end redirect controller. It holds the fetch PC and one global epoch per
// redirecting stage, accepts only redirects from current-epoch instructions
// (execute first), and reports wrong-path instructions in decode and execute.
// Assumes fewer than 2**(EPW-1) redirects are in flight at any time.
module epoch_redirect_ctl
    import rdr_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              EPW      = 8,
    parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0200,
    parameter int              PC_STEP  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_adv_i,
    input  logic            pred_valid_i,
    input  logic [XLEN-1:0] pred_pc_i,
    input  logic            dec_redir_valid_i,
    input  logic [XLEN-1:0] dec_redir_pc_i,
    input  logic [EPW-1:0]  dec_redir_eep_i,
    input  logic [EPW-1:0]  dec_redir_dep_i,
    input  logic            exe_redir_valid_i,
    input  logic [XLEN-1:0] exe_redir_pc_i,
    input  logic [EPW-1:0]  exe_redir_eep_i,
    input  logic [EPW-1:0]  dec_chk_eep_i,
    input  logic [EPW-1:0]  dec_chk_dep_i,
    input  logic [EPW-1:0]  exe_chk_eep_i,
    output logic [XLEN-1:0] fetch_pc_o,
    output logic [EPW-1:0]  fetch_eep_o,
    output logic [EPW-1:0]  fetch_dep_o,
    output logic            dec_kill_o,
    output logic            exe_kill_o
);

    localparam logic [EPW-1:0]  EP_ONE = EPW'(1);
    localparam logic [XLEN-1:0] STEP   = XLEN'(PC_STEP);

    logic            exe_take;
    logic            dec_take;
    pc_src_e         pc_src;
    logic [XLEN-1:0] tgt_pc;
    logic [EPW-1:0]  cur_eep;
    logic [EPW-1:0]  cur_dep;

    rdr_epoch_ctr #(.EPW(EPW)) u_eep_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .bump_i  (exe_take),
        .value_o (cur_eep)
    );

    rdr_epoch_ctr #(.EPW(EPW)) u_dep_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .bump_i  (dec_take),
        .value_o (cur_dep)
    );

    rdr_redirect_arb #(.XLEN(XLEN), .EPW(EPW)) u_arb (
        .fetch_adv_i (fetch_adv_i),
        .dec_valid_i (dec_redir_valid_i),
        .dec_pc_i    (dec_redir_pc_i),
        .dec_eep_i   (dec_redir_eep_i),
        .dec_dep_i   (dec_redir_dep_i),
        .exe_valid_i (exe_redir_valid_i),
        .exe_pc_i    (exe_redir_pc_i),
        .exe_eep_i   (exe_redir_eep_i),
        .cur_eep_i   (cur_eep),
        .cur_dep_i   (cur_dep),
        .exe_take_o  (exe_take),
        .dec_take_o  (dec_take),
        .src_o       (pc_src),
        .tgt_pc_o    (tgt_pc)
    );

    rdr_fetch_pc #(.XLEN(XLEN), .RESET_PC(RESET_PC), .PC_STEP(PC_STEP)) u_pc (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (pc_src),
        .tgt_pc_i     (tgt_pc),
        .pred_valid_i (pred_valid_i),
        .pred_pc_i    (pred_pc_i),
        .pc_o         (fetch_pc_o)
    );

    rdr_kill_check #(.EPW(EPW)) u_kill (
        .cur_eep_i  (cur_eep),
        .cur_dep_i  (cur_dep),
        .dec_eep_i  (dec_chk_eep_i),
        .dec_dep_i  (dec_chk_dep_i),
        .exe_eep_i  (exe_chk_eep_i),
        .dec_kill_o (dec_kill_o),
        .exe_kill_o (exe_kill_o)
    );

    assign fetch_eep_o = cur_eep;
    assign fetch_dep_o = cur_dep;

    // Port-level checks of the redirect rules.
    AST_EXE_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_redir_valid_i && exe_redir_eep_i == fetch_eep_o) |=>
        (fetch_pc_o == $past(exe_redir_pc_i) && fetch_eep_o == $past(fetch_eep_o) + EP_ONE
         && fetch_dep_o == $past(fetch_dep_o))); // R2

    AST_DEC_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_redir_valid_i && dec_redir_eep_i == fetch_eep_o && dec_redir_dep_i == fetch_dep_o
         && !(exe_redir_valid_i && exe_redir_eep_i == fetch_eep_o)) |=>
        (fetch_pc_o == $past(dec_redir_pc_i) && fetch_dep_o == $past(fetch_dep_o) + EP_ONE
         && $stable(fetch_eep_o))); // R3

    AST_EXE_OVER_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (exe_redir_valid_i && exe_redir_eep_i == fetch_eep_o && dec_redir_valid_i) |=>
        $stable(fetch_dep_o)); // R4

    AST_NO_STALE_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!(exe_redir_valid_i && exe_redir_eep_i == fetch_eep_o)
         && !(dec_redir_valid_i && dec_redir_eep_i == fetch_eep_o && dec_redir_dep_i == fetch_dep_o)) |=>
        ($stable(fetch_eep_o) && $stable(fetch_dep_o))); // R5

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_adv_i && !pred_valid_i && !exe_redir_valid_i && !dec_redir_valid_i) |=>
        (fetch_pc_o == $past(fetch_pc_o) + STEP)); // R7

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_adv_i && !exe_redir_valid_i && !dec_redir_valid_i) |=> $stable(fetch_pc_o)); // R8

    AST_EXE_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        exe_kill_o == (exe_chk_eep_i != fetch_eep_o)); // R9

endmodule

// File: tb/epoch_redirect_ctl_tb_top.sv
// Self-checking bench: sequential vector table, then directed kill, wrap and reset tests.
module epoch_redirect_ctl_tb_top;

    localparam int XLEN = 32;
    localparam int EPW  = 8;
    localparam logic [31:0] RST_PC = 32'h0000_0200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_adv_i = 1'b0;
    logic        pred_valid_i = 1'b0;
    logic [31:0] pred_pc_i = '0;
    logic        dec_redir_valid_i = 1'b0;
    logic [31:0] dec_redir_pc_i = '0;
    logic [7:0]  dec_redir_eep_i = '0;
    logic [7:0]  dec_redir_dep_i = '0;
    logic        exe_redir_valid_i = 1'b0;
    logic [31:0] exe_redir_pc_i = '0;
    logic [7:0]  exe_redir_eep_i = '0;
    logic [7:0]  dec_chk_eep_i = '0;
    logic [7:0]  dec_chk_dep_i = '0;
    logic [7:0]  exe_chk_eep_i = '0;
    logic [31:0] fetch_pc_o;
    logic [7:0]  fetch_eep_o;
    logic [7:0]  fetch_dep_o;
    logic        dec_kill_o;
    logic        exe_kill_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    epoch_redirect_ctl #(.XLEN(XLEN), .EPW(EPW), .RESET_PC(RST_PC), .PC_STEP(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_adv_i(fetch_adv_i),
        .pred_valid_i(pred_valid_i), .pred_pc_i(pred_pc_i),
        .dec_redir_valid_i(dec_redir_valid_i), .dec_redir_pc_i(dec_redir_pc_i),
        .dec_redir_eep_i(dec_redir_eep_i), .dec_redir_dep_i(dec_redir_dep_i),
        .exe_redir_valid_i(exe_redir_valid_i), .exe_redir_pc_i(exe_redir_pc_i),
        .exe_redir_eep_i(exe_redir_eep_i),
        .dec_chk_eep_i(dec_chk_eep_i), .dec_chk_dep_i(dec_chk_dep_i),
        .exe_chk_eep_i(exe_chk_eep_i),
        .fetch_pc_o(fetch_pc_o), .fetch_eep_o(fetch_eep_o), .fetch_dep_o(fetch_dep_o),
        .dec_kill_o(dec_kill_o), .exe_kill_o(exe_kill_o)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic        adv;
        logic        pv;
        logic [31:0] ppc;
        logic        dv;
        logic [31:0] dpc;
        logic [7:0]  deep;
        logic [7:0]  ddep;
        logic        xv;
        logic [31:0] xpc;
        logic [7:0]  xeep;
        logic [31:0] epc;
        logic [7:0]  eeep;
        logic [7:0]  edep;
    } vec_t;

    // Applied in order from reset (PC 0x200, epochs 0/0); expected state after one edge.
    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{4'd7,  1'b1, 1'b0, 32'h0,   1'b0, 32'h0,   8'd0, 8'd0, 1'b0, 32'h0,    8'd0, 32'h204,  8'd0, 8'd0},
        '{4'd8,  1'b0, 1'b0, 32'h0,   1'b0, 32'h0,   8'd0, 8'd0, 1'b0, 32'h0,    8'd0, 32'h204,  8'd0, 8'd0},
        '{4'd7,  1'b1, 1'b1, 32'h300, 1'b0, 32'h0,   8'd0, 8'd0, 1'b0, 32'h0,    8'd0, 32'h300,  8'd0, 8'd0},
        '{4'd2,  1'b0, 1'b0, 32'h0,   1'b0, 32'h0,   8'd0, 8'd0, 1'b1, 32'h400,  8'd0, 32'h400,  8'd1, 8'd0},
        '{4'd5,  1'b1, 1'b0, 32'h0,   1'b1, 32'h500, 8'd0, 8'd0, 1'b0, 32'h0,    8'd0, 32'h404,  8'd1, 8'd0},
        '{4'd3,  1'b0, 1'b0, 32'h0,   1'b1, 32'h500, 8'd1, 8'd0, 1'b0, 32'h0,    8'd0, 32'h500,  8'd1, 8'd1},
        '{4'd5,  1'b1, 1'b0, 32'h0,   1'b1, 32'h580, 8'd1, 8'd0, 1'b0, 32'h0,    8'd0, 32'h504,  8'd1, 8'd1},
        '{4'd4,  1'b1, 1'b0, 32'h0,   1'b1, 32'h600, 8'd1, 8'd1, 1'b1, 32'h700,  8'd1, 32'h700,  8'd2, 8'd1},
        '{4'd6,  1'b1, 1'b0, 32'h0,   1'b0, 32'h0,   8'd0, 8'd0, 1'b1, 32'h800,  8'd1, 32'h704,  8'd2, 8'd1},
        '{4'd3,  1'b0, 1'b0, 32'h0,   1'b1, 32'h900, 8'd2, 8'd1, 1'b1, 32'hA00,  8'd1, 32'h900,  8'd2, 8'd2},
        '{4'd2,  1'b1, 1'b1, 32'hBBC, 1'b0, 32'h0,   8'd0, 8'd0, 1'b1, 32'h1000, 8'd2, 32'h1000, 8'd3, 8'd2}
    };

    // Compare one value and log a failure.
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Return all request inputs to idle.
    task automatic idle_inputs();
        fetch_adv_i = 1'b0; pred_valid_i = 1'b0; pred_pc_i = '0;
        dec_redir_valid_i = 1'b0; dec_redir_pc_i = '0; dec_redir_eep_i = '0; dec_redir_dep_i = '0;
        exe_redir_valid_i = 1'b0; exe_redir_pc_i = '0; exe_redir_eep_i = '0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        string tg;
        logic [7:0] ep;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 pc", fetch_pc_o, RST_PC);
        check("R1 eep", {24'b0, fetch_eep_o}, 32'd0);
        check("R1 dep", {24'b0, fetch_dep_o}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            fetch_adv_i = VECS[i].adv; pred_valid_i = VECS[i].pv; pred_pc_i = VECS[i].ppc;
            dec_redir_valid_i = VECS[i].dv; dec_redir_pc_i = VECS[i].dpc;
            dec_redir_eep_i = VECS[i].deep; dec_redir_dep_i = VECS[i].ddep;
            exe_redir_valid_i = VECS[i].xv; exe_redir_pc_i = VECS[i].xpc;
            exe_redir_eep_i = VECS[i].xeep;
            @(negedge clk);
            tg = $sformatf("R%0d vec%0d", VECS[i].req, i);
            check({tg, " pc"}, fetch_pc_o, VECS[i].epc);
            check({tg, " eep"}, {24'b0, fetch_eep_o}, {24'b0, VECS[i].eeep});
            check({tg, " dep"}, {24'b0, fetch_dep_o}, {24'b0, VECS[i].edep});
        end
        idle_inputs();

        // R9: kill flags, combinational against epochs eep=3 dep=2
        dec_chk_eep_i = 8'd3; dec_chk_dep_i = 8'd2; exe_chk_eep_i = 8'd3; #1;
        check("R9 dec live", {31'b0, dec_kill_o}, 32'd0);
        check("R9 exe live", {31'b0, exe_kill_o}, 32'd0);
        dec_chk_eep_i = 8'd2; exe_chk_eep_i = 8'd2; #1;
        check("R9 dec stale eep", {31'b0, dec_kill_o}, 32'd1);
        check("R9 exe stale eep", {31'b0, exe_kill_o}, 32'd1);
        dec_chk_eep_i = 8'd3; dec_chk_dep_i = 8'd1; exe_chk_eep_i = 8'd3; #1;
        check("R9 dec stale dep", {31'b0, dec_kill_o}, 32'd1);
        check("R9 exe ignores dep", {31'b0, exe_kill_o}, 32'd0);
        @(negedge clk);

        // R10: 253 more execute redirects take the execute epoch 3 -> 0
        ep = 8'd3;
        for (int k = 0; k < 253; k++) begin
            exe_redir_valid_i = 1'b1; exe_redir_eep_i = ep; exe_redir_pc_i = 32'h2000 + 32'(k) * 4;
            @(negedge clk);
            ep = ep + 8'd1;
        end
        idle_inputs();
        check("R10 wrap eep", {24'b0, fetch_eep_o}, 32'd0);
        check("R10 wrap pc", fetch_pc_o, 32'h2000 + 32'd252 * 4);
        check("R10 dep held", {24'b0, fetch_dep_o}, 32'd2);
        // R6: old tag 0xFF is stale after the wrap
        exe_redir_valid_i = 1'b1; exe_redir_eep_i = 8'hFF; exe_redir_pc_i = 32'hDEAD0;
        @(negedge clk);
        idle_inputs();
        check("R6 stale after wrap pc", fetch_pc_o, 32'h2000 + 32'd252 * 4);
        check("R6 stale after wrap eep", {24'b0, fetch_eep_o}, 32'd0);

        // R1: reset in the middle of a run
        rst_n = 1'b0; fetch_adv_i = 1'b1;
        @(negedge clk);
        rst_n = 1'b1; fetch_adv_i = 1'b0;
        check("R1 mid pc", fetch_pc_o, RST_PC);
        check("R1 mid eep", {24'b0, fetch_eep_o}, 32'd0);
        check("R1 mid dep", {24'b0, fetch_dep_o}, 32'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule